// File: doc/BRIEF.md
# Cartridge Register Chip with Auxiliary Pins

This block is a small write-only register file that sits on a cartridge bus and produces bank-select bits. A 4-bit accumulator can either step by one or load a staged nibble, which is optionally complemented. Two upper register bits are loaded directly. A 5-bit output latch captures the register whenever a write lands outside the register window. The latch's top bit is flipped by a global invert flag.

Beside this core there are four auxiliary pins: two plain inputs, one pin that is either an input or a driven output, and one output. Whenever the invert flag is written, the auxiliary outputs are recomputed from the newly written flag, the selected inputs and the top data bit. A direction input chooses whether the shared pin is sampled or driven. The board normally ties `pin_a` high and `pin_b` low, and selects output mode for the shared pin.

Top module: `regchip_aux`

## Requirements
- R1: Every write address is ANDed with 0xE103 before it is decoded. Masked values 0x4100, 0x4101, 0x4102 and 0x4103 select the accumulator, invert, stage and mode registers. Mirrors such as 0x51FC (accumulator) and 0x5FFE (stage) therefore hit the same registers, and any other masked value is a latch write.
- R2: A write to 0x4100 with increment mode off loads register bits 3:0 with the staged nibble. The nibble is XORed with 0xF when the invert flag is set.
- R3: A write to 0x4100 with increment mode on adds one to register bits 3:0, wrapping from 0xF to 0x0. Register bits 5:4 are left unchanged.
- R4: A write to 0x4102 loads register bits 5:4 from data bits 5:4 and staged bits 2:0 from data bits 2:0. Staged bit 3 ignores data bit 3 and instead toggles when the invert flag is set.
- R5: A write to 0x4103 sets increment mode from data bit 0.
- R6: In output mode (`aux_dir_in` = 0), a write to 0x4101 sets the invert flag from data bit 0. In the same cycle it drives `aux_out` with `pin_b` if the new flag is 1, otherwise with `pin_a`, and sets `o3` to that value OR data bit 5.
- R7: In input mode (`aux_dir_in` = 1), a write to 0x4101 sets `o3` to the new flag ? `aux_in` : `pin_a`, ORed with data bit 5. In this mode `aux_out` keeps its value and `pin_b` has no effect.
- R8: `aux_oe` is 1 exactly when `aux_dir_in` is 0.
- R9: A latch write sets `latch_q[3:0]` to register bits 3:0 and `latch_q[4]` to register bit 4 XOR the invert flag. The register itself is unchanged.
- R10: After reset the register, staged nibble, invert flag, increment mode, latch, `o3` and `aux_out` are all zero.
- R11: While `wr_en` is low, the register, latch, `o3` and `aux_out` hold their values, whatever the address, data and pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 16 | Write address |
| wdata | input | 6 | Write data |
| pin_a | input | 1 | Auxiliary input A |
| pin_b | input | 1 | Auxiliary input B |
| aux_in | input | 1 | Sampled value of the shared auxiliary pin |
| aux_dir_in | input | 1 | 1 = shared pin is an input, 0 = driven |
| latch_q | output | 5 | Output latch |
| o3 | output | 1 | Auxiliary output pin |
| aux_out | output | 1 | Driven value of the shared pin |
| aux_oe | output | 1 | Output enable of the shared pin |
| reg_q | output | 6 | Register contents for readback |

## Verification
A write to the invert register changes the flag and, in the same cycle, selects which pin feeds the auxiliary outputs. The bench therefore sets `pin_a` and `pin_b` to opposite levels and writes a flag value that differs from the current one, so using the stale flag gives a visibly different `aux_out` or `o3`. Likewise, the stage write toggles its top bit from the invert flag already held, and a later accumulator load shows whether the toggle took place.

// File: rtl/regchip_pkg.sv
package regchip_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_ACC,
      OP_INV,
      OP_STG,
      OP_INC,
      OP_LATCH
   } rc_op_e;

endpackage

// File: rtl/rc_decode.sv
module rc_decode
   import regchip_pkg::*;
#(
   parameter int          ADDR_W = 16,
   parameter logic [15:0] MASK   = 16'hE103,
   parameter logic [15:0] BASE   = 16'h4100
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output rc_op_e            op
);

   localparam logic [ADDR_W-1:0] M = ADDR_W'(MASK);
   localparam logic [ADDR_W-1:0] B = ADDR_W'(BASE);

   logic [ADDR_W-1:0] masked;
   assign masked = addr & M;

   always_comb begin
      op = OP_IDLE;
      if (wr_en) begin
         if      (masked == B)              op = OP_ACC;
         else if (masked == B + ADDR_W'(1)) op = OP_INV;
         else if (masked == B + ADDR_W'(2)) op = OP_STG;
         else if (masked == B + ADDR_W'(3)) op = OP_INC;
         else                               op = OP_LATCH;
      end
   end

endmodule

// File: rtl/rc_core.sv
module rc_core
   import regchip_pkg::*;
#(
   parameter int DATA_W       = 6,
   parameter int ACC_W        = 4,
   parameter bit STAGE_TOGGLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rc_op_e            op,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] reg_q,
   output logic              inv_q
);

   localparam int HI_W = DATA_W - ACC_W;

   logic [ACC_W-1:0] acc_q, stage_q;
   logic [HI_W-1:0]  hi_q;
   logic             inc_q;
   logic             stage_top_nx;

   // variant: top staged bit follows invert, or loads from data
   assign stage_top_nx = STAGE_TOGGLE ? (stage_q[ACC_W-1] ^ inv_q)
                                      : wdata[ACC_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         stage_q <= '0;
         hi_q    <= '0;
         inc_q   <= 1'b0;
         inv_q   <= 1'b0;
      end else begin
         case (op)
            OP_ACC: acc_q <= inc_q ? acc_q + ACC_W'(1) : stage_q ^ {ACC_W{inv_q}};
            OP_INV: inv_q <= wdata[0];
            OP_STG: begin
               hi_q    <= wdata[DATA_W-1:ACC_W];
               stage_q <= {stage_top_nx, wdata[ACC_W-2:0]};
            end
            OP_INC: inc_q <= wdata[0];
            default: ;
         endcase
      end
   end

   assign reg_q = {hi_q, acc_q};

   assert_acc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ACC && inc_q) |=> (acc_q == $past(acc_q) + ACC_W'(1)) && $stable(hi_q));

   assert_acc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ACC && !inc_q) |=> acc_q == $past(stage_q ^ {ACC_W{inv_q}}));

   assert_stage_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_STG && STAGE_TOGGLE) |=> stage_q[ACC_W-1] == $past(stage_q[ACC_W-1] ^ inv_q));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_IDLE) |=> $stable(reg_q) && $stable(inv_q));

endmodule

// File: rtl/rc_aux.sv
module rc_aux
   import regchip_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  rc_op_e op,
   input  logic   d_inv,
   input  logic   d_force,
   input  logic   pin_a,
   input  logic   pin_b,
   input  logic   aux_in,
   input  logic   aux_dir_in,
   output logic   o3_q,
   output logic   aux_out_q,
   output logic   aux_oe
);

   logic drive_nx;
   assign drive_nx = d_inv ? pin_b : pin_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o3_q      <= 1'b0;
         aux_out_q <= 1'b0;
      end else if (op == OP_INV) begin
         if (aux_dir_in) begin
            o3_q <= (d_inv ? aux_in : pin_a) | d_force;
         end else begin
            aux_out_q <= drive_nx;
            o3_q      <= drive_nx | d_force;
         end
      end
   end

   assign aux_oe = !aux_dir_in;

   assert_o3_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INV && !aux_dir_in) |=> o3_q == (aux_out_q | $past(d_force)));

   assert_hold_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INV && aux_dir_in) |=> $stable(aux_out_q));

endmodule

// File: rtl/rc_latch.sv
module rc_latch
   import regchip_pkg::*;
#(
   parameter int LATCH_W = 5,
   parameter int ACC_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  rc_op_e             op,
   input  logic [LATCH_W-1:0] src,
   input  logic               inv,
   output logic [LATCH_W-1:0] latch_q
);

   logic [LATCH_W-1:0] nx;

   for (genvar i = 0; i < LATCH_W; i++) begin : g_bit
      if (i < ACC_W) begin : g_plain
         assign nx[i] = src[i];
      end else begin : g_flip
         assign nx[i] = src[i] ^ inv;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               latch_q <= '0;
      else if (op == OP_LATCH)  latch_q <= nx;
   end

   assert_latch_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LATCH) |=> latch_q[ACC_W-1:0] == $past(src[ACC_W-1:0]));

   assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_LATCH) |=> $stable(latch_q));

endmodule

// File: rtl/regchip_aux.sv
module regchip_aux
   import regchip_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          DATA_W       = 6,
   parameter int          ACC_W        = 4,
   parameter int          LATCH_W      = 5,
   parameter logic [15:0] ADDR_MASK    = 16'hE103,
   parameter logic [15:0] REG_BASE     = 16'h4100,
   parameter bit          STAGE_TOGGLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               pin_a,
   input  logic               pin_b,
   input  logic               aux_in,
   input  logic               aux_dir_in,
   output logic [LATCH_W-1:0] latch_q,
   output logic               o3,
   output logic               aux_out,
   output logic               aux_oe,
   output logic [DATA_W-1:0]  reg_q
);

   if (ACC_W < 2 || DATA_W <= ACC_W) begin : g_bad_acc
      $error("regchip_aux: ACC_W must be at least 2 and below DATA_W");
   end
   if (LATCH_W <= ACC_W || LATCH_W > DATA_W) begin : g_bad_latch
      $error("regchip_aux: LATCH_W must lie in (ACC_W, DATA_W]");
   end
   if (ADDR_W > 16) begin : g_bad_addr
      $error("regchip_aux: ADDR_W must not exceed the mask width");
   end

   rc_op_e op;
   logic   inv;

   rc_decode #(.ADDR_W(ADDR_W), .MASK(ADDR_MASK), .BASE(REG_BASE)) u_dec (
      .wr_en(wr_en), .addr(addr), .op(op)
   );

   rc_core #(.DATA_W(DATA_W), .ACC_W(ACC_W), .STAGE_TOGGLE(STAGE_TOGGLE)) u_core (
      .clk(clk), .rst_n(rst_n), .op(op), .wdata(wdata), .reg_q(reg_q), .inv_q(inv)
   );

   rc_aux u_aux (
      .clk(clk), .rst_n(rst_n), .op(op),
      .d_inv(wdata[0]), .d_force(wdata[DATA_W-1]),
      .pin_a(pin_a), .pin_b(pin_b), .aux_in(aux_in), .aux_dir_in(aux_dir_in),
      .o3_q(o3), .aux_out_q(aux_out), .aux_oe(aux_oe)
   );

   rc_latch #(.LATCH_W(LATCH_W), .ACC_W(ACC_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .op(op), .src(reg_q[LATCH_W-1:0]), .inv(inv),
      .latch_q(latch_q)
   );

endmodule

// File: tb/tb_regchip_aux.sv
`timescale 1ns/100ps
module tb_regchip_aux;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] addr = '0;
   logic [5:0]  wdata = '0;
   logic        pin_a = 1'b1, pin_b = 1'b0, aux_in = 1'b0, aux_dir_in = 1'b0;
   logic [4:0]  latch_q;
   logic        o3, aux_out, aux_oe;
   logic [5:0]  reg_q;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   regchip_aux dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .pin_a(pin_a), .pin_b(pin_b), .aux_in(aux_in), .aux_dir_in(aux_dir_in),
      .latch_q(latch_q), .o3(o3), .aux_out(aux_out), .aux_oe(aux_oe), .reg_q(reg_q)
   );

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [5:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      chk("R10", "reg_q", 8'(reg_q), 8'h00);
      chk("R10", "latch_q", 8'(latch_q), 8'h00);
      chk("R10", "o3", 8'(o3), 8'h0);
      chk("R10", "aux_out", 8'(aux_out), 8'h0);
      chk("R8", "aux_oe out mode", 8'(aux_oe), 8'h1);
   endtask

   task automatic t_load;
      wr(16'h4102, 6'b101101);
      wr(16'h4100, 6'h00);
      chk("R4", "stage load, data bit3 ignored", 8'(reg_q), 8'h25);
      chk("R2", "plain load", 8'(reg_q[3:0]), 8'h5);
   endtask

   task automatic t_invert;
      wr(16'h4101, 6'h01);
      chk("R6", "aux_out picks pin_b", 8'(aux_out), 8'h0);
      chk("R6", "o3", 8'(o3), 8'h0);
      wr(16'h4100, 6'h00);
      chk("R2", "inverted load", 8'(reg_q), 8'h2A);
   endtask

   task automatic t_toggle;
      wr(16'h4102, 6'b010000);
      wr(16'h4100, 6'h00);
      chk("R4", "stage top toggled on", 8'(reg_q), 8'h17);
      wr(16'h4102, 6'b011000);
      wr(16'h4100, 6'h00);
      chk("R4", "stage top toggled off", 8'(reg_q), 8'h1F);
   endtask

   task automatic t_latch;
      wr(16'h8000, 6'h3F);
      chk("R9", "latch with invert", 8'(latch_q), 8'h0F);
      chk("R9", "reg unchanged", 8'(reg_q), 8'h1F);
      pin_a = 1'b1;
      wr(16'h4101, 6'h00);
      chk("R6", "aux_out picks pin_a", 8'(aux_out), 8'h1);
      chk("R6", "o3 follows aux_out", 8'(o3), 8'h1);
      wr(16'h0000, 6'h00);
      chk("R9", "latch without invert", 8'(latch_q), 8'h1F);
   endtask

   task automatic t_incr;
      wr(16'h4103, 6'h01);
      wr(16'h4100, 6'h00);
      chk("R3", "wrap F to 0", 8'(reg_q), 8'h10);
      wr(16'h4100, 6'h00);
      chk("R3", "step", 8'(reg_q), 8'h11);
      wr(16'h4103, 6'h00);
      wr(16'h4100, 6'h00);
      chk("R5", "mode off loads stage", 8'(reg_q), 8'h10);
   endtask

   task automatic t_mirror;
      wr(16'h5FFE, 6'b110011);
      chk("R1", "stage mirror hi bits", 8'(reg_q), 8'h30);
      wr(16'h51FC, 6'h00);
      chk("R1", "acc mirror load", 8'(reg_q), 8'h33);
      wr(16'h4000, 6'h00);
      chk("R1", "outside window latches", 8'(latch_q), 8'h13);
      chk("R1", "outside window keeps reg", 8'(reg_q), 8'h33);
   endtask

   task automatic t_aux_input;
      @(negedge clk);
      aux_dir_in = 1'b1; pin_a = 1'b0; pin_b = 1'b1; aux_in = 1'b0;
      #1;
      chk("R8", "aux_oe in mode", 8'(aux_oe), 8'h0);
      wr(16'h4101, 6'h00);
      chk("R7", "o3 from pin_a", 8'(o3), 8'h0);
      chk("R7", "aux_out held", 8'(aux_out), 8'h1);
      aux_in = 1'b1;
      wr(16'h4101, 6'h01);
      chk("R7", "o3 from aux_in", 8'(o3), 8'h1);
      aux_in = 1'b0;
      wr(16'h4101, 6'h21);
      chk("R7", "o3 forced by bit5", 8'(o3), 8'h1);
      wr(16'h4101, 6'h01);
      chk("R7", "pin_b ignored", 8'(o3), 8'h0);
      chk("R7", "aux_out still held", 8'(aux_out), 8'h1);
   endtask

   task automatic t_aux_output;
      @(negedge clk);
      aux_dir_in = 1'b0; pin_a = 1'b0; pin_b = 1'b1;
      #1;
      chk("R8", "aux_oe back on", 8'(aux_oe), 8'h1);
      wr(16'h4101, 6'h20);
      chk("R6", "aux_out pin_a", 8'(aux_out), 8'h0);
      chk("R6", "o3 forced", 8'(o3), 8'h1);
      wr(16'h4101, 6'h01);
      chk("R6", "aux_out pin_b", 8'(aux_out), 8'h1);
      wr(16'h4101, 6'h00);
      chk("R6", "new flag selects same cycle", 8'(aux_out), 8'h0);
      chk("R6", "o3 same cycle", 8'(o3), 8'h0);
   endtask

   task automatic t_hold;
      logic [5:0] r0;
      logic [4:0] l0;
      logic       o0, a0;
      r0 = reg_q; l0 = latch_q; o0 = o3; a0 = aux_out;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         wr_en = 1'b0;
         addr  = (i % 2 == 0) ? 16'h4100 : 16'h4101;
         wdata = 6'(i * 11);
         pin_a = ~pin_a; pin_b = ~pin_b; aux_in = ~aux_in;
      end
      @(negedge clk);
      chk("R11", "reg held", 8'(reg_q), 8'(r0));
      chk("R11", "latch held", 8'(latch_q), 8'(l0));
      chk("R11", "o3 held", 8'(o3), 8'(o0));
      chk("R11", "aux_out held", 8'(aux_out), 8'(a0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_invert();
      t_toggle();
      t_latch();
      t_incr();
      t_mirror();
      t_aux_input();
      t_aux_output();
      t_hold();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule